// File: doc/BRIEF.md
# Fast Ethernet Receive Symbol Decoder

This block sits behind the clock-recovery stage of a 100 Mb/s twisted-pair receiver. One retimed line bit arrives on every serial clock (125 MBd). The block undoes the NRZI line coding and removes the scrambler with a self-synchronising key generator. It then finds the 5-bit code-group boundary at the start-of-stream delimiter and translates each code group back into a 4-bit data nibble for an MII-style receive interface. The data-valid, error and nibble outputs change only on clocks where the nibble strobe `rx_stb` is high, once every five serial clocks.

The key generator locks on the idle stream that precedes every frame. Once it has predicted `LOCK_BITS` consecutive idle bits correctly it reports lock, and the lock is kept from then on. A bypass input skips descrambling, alignment and decoding. In that mode each raw 5-bit group of NRZ line bits is presented directly, with the error output as its most significant bit and data-valid held low.

Top module: `fe_rx_decoder`

## Requirements
- R1: NRZI decoding treats a change of the line level between consecutive bits as a 1 and no change as a 0.
- R2: `scr_locked` rises no earlier than `LOCK_BITS` and no later than `LOCK_BITS`+14 serial clocks after reset release while the line carries scrambled idle (all ones before scrambling, key recurrence k[n]=k[n-11] xor k[n-9]), and once high it stays high until reset.
- R3: `rx_stb` pulses at most once every five clocks; inside a frame the strobes fall exactly five clocks apart.
- R4: After the descrambled pair 11000 then 10001 (first received bit leftmost), each following 5-bit group is decoded as data, with `rx_dv`=1 and `rx_er`=0, using 11110=0, 01001=1, 10100=2, 10101=3, 01010=4, 01011=5, 01110=6, 01111=7, 10010=8, 10011=9, 10110=A, 10111=B, 11010=C, 11011=D, 11100=E, 11101=F.
- R5: The group 01101 ends the frame: `rx_dv` is low on that nibble strobe and on every strobe until the next start pair.
- R6: A group inside a frame that is neither data nor 01101 gives `rx_dv`=1, `rx_er`=1 and `rxd`=0000 for that nibble.
- R7: Nibble strobes outside a frame carry `rx_dv`=0, `rx_er`=0 and `rxd`=0000.
- R8: With `bypass` high, each strobe carries the last five NRZ bits as {`rx_er`,`rxd`}, the earliest received bit in `rx_er`, and `rx_dv` is low on every clock after `bypass` is sampled high.
- R9: During reset all outputs are low.
- R10: Every new start pair re-aligns the group boundary, whatever the bit offset of the previous frame, including after a bypass period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock, one retimed line bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| line_bit | input | 1 | Retimed line bit (NRZI coded, scrambled) |
| bypass | input | 1 | Raw code-group mode when high |
| rx_stb | output | 1 | Nibble strobe, one clock wide |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error, or group MSB in bypass |
| rxd | output | 4 | Receive nibble, or group low bits in bypass |
| scr_locked | output | 1 | Descrambler lock indication |

## Verification
On every cycle the assertions check that the outputs hold between strobes and that strobes never come closer than five clocks. They also check that data-valid rises only on a strobe and stays low after `bypass`, and that the lock flag never drops while the lock counter stays within its bound. Only the bench scenarios can show that the right nibbles come out: the full code table, invalid groups in mid-frame, realignment at new bit offsets, and the bit order of raw groups in bypass. The same holds for the lock time against an independently scrambled idle stream.

// File: rtl/fe_rx_pkg.sv
package fe_rx_pkg;

    localparam int unsigned GRP_W = 5;
    localparam int unsigned NIB_W = 4;

    localparam logic [GRP_W-1:0] CG_J = 5'b11000;
    localparam logic [GRP_W-1:0] CG_K = 5'b10001;
    localparam logic [GRP_W-1:0] CG_T = 5'b01101;

    typedef struct packed {
        logic             valid;
        logic [NIB_W-1:0] nib;
    } dec_t;

    // 5-bit code group to data nibble; valid is low for control or illegal groups
    function automatic dec_t dec_group(input logic [GRP_W-1:0] g);
        dec_t r;
        r.valid = 1'b1;
        case (g)
            5'b11110: r.nib = 4'h0;
            5'b01001: r.nib = 4'h1;
            5'b10100: r.nib = 4'h2;
            5'b10101: r.nib = 4'h3;
            5'b01010: r.nib = 4'h4;
            5'b01011: r.nib = 4'h5;
            5'b01110: r.nib = 4'h6;
            5'b01111: r.nib = 4'h7;
            5'b10010: r.nib = 4'h8;
            5'b10011: r.nib = 4'h9;
            5'b10110: r.nib = 4'hA;
            5'b10111: r.nib = 4'hB;
            5'b11010: r.nib = 4'hC;
            5'b11011: r.nib = 4'hD;
            5'b11100: r.nib = 4'hE;
            5'b11101: r.nib = 4'hF;
            default: begin
                r.valid = 1'b0;
                r.nib   = '0;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fe_rx_nrzi.sv
module fe_rx_nrzi (
    input  logic clk,
    input  logic rst_n,
    input  logic line_bit,
    output logic nrz_bit
);

    typedef struct packed {
        logic prev;
        logic nrz;
    } nz_st_t;

    nz_st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.prev = line_bit;
        s_d.nrz  = line_bit ^ s_q.prev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign nrz_bit = s_q.nrz;

endmodule

// File: rtl/fe_rx_descr.sv
module fe_rx_descr #(
    parameter int LFSR_W    = 11,
    parameter int TAP_A     = 10,
    parameter int TAP_B     = 8,
    parameter int LOCK_BITS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scr_bit,
    output logic plain_bit,
    output logic locked
);

    localparam int CNT_W = $clog2(LOCK_BITS + 1);

    typedef struct packed {
        logic [LFSR_W-1:0] lfsr;
        logic [CNT_W-1:0]  cnt;
        logic              locked;
    } ds_st_t;

    ds_st_t s_d, s_q;
    logic   pred;

    assign pred = s_q.lfsr[TAP_A] ^ s_q.lfsr[TAP_B];

    always_comb begin
        s_d = s_q;
        if (s_q.locked) begin
            // free-running key generator
            s_d.lfsr = {s_q.lfsr[LFSR_W-2:0], pred};
        end else begin
            // idle is all ones, so the key bit is the inverted line bit
            s_d.lfsr = {s_q.lfsr[LFSR_W-2:0], ~scr_bit};
            if (pred == ~scr_bit) begin
                if (s_q.cnt == CNT_W'(LOCK_BITS - 1)) begin
                    s_d.locked = 1'b1;
                    s_d.cnt    = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end else begin
                s_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign plain_bit = s_q.locked ? (scr_bit ^ pred) : 1'b1;
    assign locked    = s_q.locked;

    // R2
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.locked |=> s_q.locked);

    // R2
    lock_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.locked |-> (s_q.cnt < CNT_W'(LOCK_BITS)));

endmodule

// File: rtl/fe_rx_framer.sv
module fe_rx_framer
    import fe_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             plain_bit,
    input  logic             raw_bit,
    input  logic             locked,
    input  logic             bypass,
    output logic             rx_stb,
    output logic             rx_dv,
    output logic             rx_er,
    output logic [NIB_W-1:0] rxd
);

    localparam int PH_W = $clog2(GRP_W);
    localparam int SH_W = 2 * GRP_W;

    typedef struct packed {
        logic [SH_W-1:0]  sh;
        logic [GRP_W-2:0] raw;
        logic [PH_W-1:0]  ph;
        logic             in_frame;
        logic             stb;
        logic             dv;
        logic             er;
        logic [NIB_W-1:0] rxd;
    } fr_st_t;

    fr_st_t            s_d, s_q;
    logic [SH_W-1:0]   sh_n;
    logic [GRP_W-1:0]  raw_n;
    logic              sof_hit;
    dec_t              dec_w;

    always_comb begin
        s_d     = s_q;
        s_d.stb = 1'b0;
        sh_n    = {s_q.sh[SH_W-2:0], plain_bit};
        raw_n   = {s_q.raw, raw_bit};
        s_d.sh  = sh_n;
        s_d.raw = raw_n[GRP_W-2:0];
        dec_w   = dec_group(sh_n[GRP_W-1:0]);
        sof_hit = !bypass && locked && !s_q.in_frame && (sh_n == {CG_J, CG_K});

        if (sof_hit) begin
            s_d.ph       = '0;
            s_d.in_frame = 1'b1;
        end else if (s_q.ph == PH_W'(GRP_W - 1)) begin
            s_d.ph  = '0;
            s_d.stb = 1'b1;
            if (bypass) begin
                s_d.dv               = 1'b0;
                {s_d.er, s_d.rxd}    = raw_n;
            end else if (s_q.in_frame) begin
                if (sh_n[GRP_W-1:0] == CG_T) begin
                    s_d.in_frame = 1'b0;
                    s_d.dv       = 1'b0;
                    s_d.er       = 1'b0;
                    s_d.rxd      = '0;
                end else if (dec_w.valid) begin
                    s_d.dv  = 1'b1;
                    s_d.er  = 1'b0;
                    s_d.rxd = dec_w.nib;
                end else begin
                    s_d.dv  = 1'b1;
                    s_d.er  = 1'b1;
                    s_d.rxd = '0;
                end
            end else begin
                s_d.dv  = 1'b0;
                s_d.er  = 1'b0;
                s_d.rxd = '0;
            end
        end else begin
            s_d.ph = s_q.ph + 1'b1;
        end

        if (bypass) begin
            s_d.dv       = 1'b0;
            s_d.in_frame = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rx_stb = s_q.stb;
    assign rx_dv  = s_q.dv;
    assign rx_er  = s_q.er;
    assign rxd    = s_q.rxd;

    // R8
    bypass_dv_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |=> !s_q.dv);

    // R3
    stb_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.stb |-> (!$past(s_q.stb, 1) && !$past(s_q.stb, 2) &&
                     !$past(s_q.stb, 3) && !$past(s_q.stb, 4)));

    // R4
    dv_rise_on_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.dv) |-> s_q.stb);

    // R7
    hold_between_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.stb |-> ($stable(s_q.er) && $stable(s_q.rxd)));

endmodule

// File: rtl/fe_rx_decoder.sv
module fe_rx_decoder #(
    parameter int LOCK_BITS = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_bit,
    input  logic       bypass,
    output logic       rx_stb,
    output logic       rx_dv,
    output logic       rx_er,
    output logic [3:0] rxd,
    output logic       scr_locked
);

    logic nrz_w;
    logic plain_w;
    logic lock_w;

    fe_rx_nrzi u_nrzi (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_bit (line_bit),
        .nrz_bit  (nrz_w)
    );

    fe_rx_descr #(
        .LFSR_W    (11),
        .TAP_A     (10),
        .TAP_B     (8),
        .LOCK_BITS (LOCK_BITS)
    ) u_descr (
        .clk       (clk),
        .rst_n     (rst_n),
        .scr_bit   (nrz_w),
        .plain_bit (plain_w),
        .locked    (lock_w)
    );

    fe_rx_framer u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .plain_bit (plain_w),
        .raw_bit   (nrz_w),
        .locked    (lock_w),
        .bypass    (bypass),
        .rx_stb    (rx_stb),
        .rx_dv     (rx_dv),
        .rx_er     (rx_er),
        .rxd       (rxd)
    );

    assign scr_locked = lock_w;

endmodule

// File: tb/test_fe_rx_decoder.sv
module test_fe_rx_decoder;

    localparam int LOCK_BITS = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_bit = 1'b0;
    logic       bypass = 1'b0;
    logic       rx_stb, rx_dv, rx_er, scr_locked;
    logic [3:0] rxd;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int lock_cyc = -1;
    int last_stb = -100;
    bit last_dv = 1'b0;

    bit         kq[$];
    bit         hist[$];
    logic       line_state = 1'b0;
    logic [4:0] exp_q[$];

    always #2 clk = ~clk;

    fe_rx_decoder #(.LOCK_BITS(LOCK_BITS)) i_fe_rx_decoder (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_bit   (line_bit),
        .bypass     (bypass),
        .rx_stb     (rx_stb),
        .rx_dv      (rx_dv),
        .rx_er      (rx_er),
        .rxd        (rxd),
        .scr_locked (scr_locked)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] enc(input logic [3:0] n);
        case (n)
            4'h0: return 5'b11110;  4'h1: return 5'b01001;
            4'h2: return 5'b10100;  4'h3: return 5'b10101;
            4'h4: return 5'b01010;  4'h5: return 5'b01011;
            4'h6: return 5'b01110;  4'h7: return 5'b01111;
            4'h8: return 5'b10010;  4'h9: return 5'b10011;
            4'hA: return 5'b10110;  4'hB: return 5'b10111;
            4'hC: return 5'b11010;  4'hD: return 5'b11011;
            4'hE: return 5'b11100;  default: return 5'b11101;
        endcase
    endfunction

    // scramble one plain bit and drive it NRZI coded
    task automatic send_bit(input bit p);
        bit k;
        bit s;
        @(negedge clk);
        k = kq[0] ^ kq[2];
        kq.push_back(k);
        void'(kq.pop_front());
        s = p ^ k;
        line_state = line_state ^ s;
        line_bit = line_state;
        hist.push_back(s);
        if (hist.size() > 12) void'(hist.pop_front());
    endtask

    task automatic send_group(input logic [4:0] g);
        for (int i = 4; i >= 0; i--) send_bit(g[i]);
    endtask

    task automatic send_idle(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b1);
    endtask

    task automatic send_data(input logic [3:0] n);
        exp_q.push_back({1'b0, n});
        send_group(enc(n));
    endtask

    task automatic send_bad(input logic [4:0] g);
        exp_q.push_back(5'b10000);
        send_group(g);
    endtask

    task automatic send_sof();
        send_group(5'b11000);
        send_group(5'b10001);
    endtask

    task automatic send_eof();
        send_group(5'b01101);
        send_group(5'b00111);
    endtask

    task automatic end_check(input string tag);
        chk(exp_q.size() == 0, tag, exp_q.size(), 0);
        exp_q.delete();
    endtask

    // per-clock reference comparison
    always @(posedge clk) begin
        logic [4:0] g;
        logic [4:0] e;
        int n;
        #1;
        if (rst_n) begin
            cyc++;
            if (scr_locked && lock_cyc < 0) begin
                lock_cyc = cyc;
                chk(cyc >= LOCK_BITS && cyc <= LOCK_BITS + 14, "R2 lock time", cyc, LOCK_BITS);
            end
            if (lock_cyc >= 0) chk(scr_locked, "R2 lock sticky", scr_locked, 1);
            if (bypass) begin
                chk(!rx_dv, "R8 dv low in bypass", rx_dv, 0);
                if (rx_stb) begin
                    n = hist.size();
                    g = {hist[n-6], hist[n-5], hist[n-4], hist[n-3], hist[n-2]};
                    chk({rx_er, rxd} == g, "R1 R8 raw group", {rx_er, rxd}, g);
                end
            end else if (rx_stb) begin
                chk(cyc - last_stb >= 5, "R3 strobe spacing", cyc - last_stb, 5);
                if (rx_dv && last_dv)
                    chk(cyc - last_stb == 5, "R3 nibble period", cyc - last_stb, 5);
                if (rx_dv) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R5 dv after end", {rx_er, rxd}, 0);
                    end else begin
                        e = exp_q.pop_front();
                        if (e[4]) chk({rx_er, rxd} == e, "R6 invalid group", {rx_er, rxd}, e);
                        else      chk({rx_er, rxd} == e, "R4 data nibble", {rx_er, rxd}, e);
                    end
                end else begin
                    chk(!rx_er && rxd == 4'h0, "R7 idle nibble", {rx_er, rxd}, 0);
                end
            end
            if (rx_stb) begin
                last_stb = cyc;
                last_dv  = rx_dv;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=0 exp=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 11; i++) kq.push_back(i % 3 == 0);
        repeat (4) @(posedge clk);
        #1;
        // R9
        chk({rx_stb, rx_dv, rx_er, rxd, scr_locked} == 8'h00, "R9 reset outputs",
            {rx_stb, rx_dv, rx_er, rxd, scr_locked}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        send_idle(LOCK_BITS + 40);
        chk(scr_locked, "R2 locked on idle", scr_locked, 1);

        // every data code
        send_sof();
        for (int n = 0; n < 16; n++) send_data(4'(n));
        send_eof();
        send_idle(23);
        end_check("R5 frame end all codes");

        // invalid groups mid-frame
        send_sof();
        send_data(4'h5);
        send_bad(5'b00100);
        send_data(4'hA);
        send_bad(5'b00000);
        send_data(4'h3);
        send_eof();
        send_idle(17);
        end_check("R6 frame end invalid");

        // new offset, random payload
        send_sof();
        for (int n = 0; n < 40; n++) send_data(4'($urandom_range(15, 0)));
        send_eof();
        send_idle(31);
        end_check("R10 realign random");

        // raw groups
        bypass = 1'b1;
        for (int n = 0; n < 60; n++) send_bit(1'($urandom_range(1, 0)));
        send_idle(12);
        bypass = 1'b0;
        send_idle(20);

        send_sof();
        for (int n = 0; n < 8; n++) send_data(4'($urandom_range(15, 0)));
        send_eof();
        send_idle(14);
        end_check("R10 realign after bypass");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule